// File: doc/BRIEF.md
# Endian-Adapting Local Address Decoder

This block sits between a host access port and a row of plug-in module slots. Each host access names one of four targets. The first is a small byte-addressed configuration space that holds three endian flags. The second is a register window that packs slot, sub-space and offset into one address. The third is a memory window for 16-bit module memory and the fourth is a memory window for 8-bit module memory. The decoder turns each access into one module request. That request carries a slot number, a sub-space code, an offset, a size and the write data. Read data from the module comes back on the host side.

Two windows can be switched to big-endian byte order, each by its own configuration flag. A byte access to such a window has the least significant address bit inverted. A halfword access to such a window has its two data bytes exchanged in both directions. The 8-bit memory window always passes data through unchanged. A slot-present mask keeps accesses away from empty slots. A read from an empty slot returns zero.

The sequencing is a three-state machine. `ST_IDLE` accepts an access and moves to `ST_ISSUE`. `ST_ISSUE` presents the module request for one cycle and moves to `ST_DONE`. `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`. No state waits on anything, so every accepted access takes exactly three cycles.

Top module: `laddr_endian_decoder`

## Requirements
- R1: After reset `acc_ready` is 1, while `done` and `mod_req` are 0. All three endian flags are 0, so every window starts little-endian.
- R2: Register window (`acc_win`=1). The slot is address bits [9:8] and bits [7:6] select the sub-space. A value of 3 gives interrupt space, 2 gives ID space, and 0 or 1 give I/O space. The offset is the address masked with 0x3F for ID and interrupt, and with 0x7F for I/O. Sub-space codes on `mod_space` are I/O=0, ID=1, interrupt=2, memory=3.
- R3: 16-bit memory window (`acc_win`=2). The offset is address bits [22:0], the slot is bits [24:23], and the sub-space is memory.
- R4: 8-bit memory window (`acc_win`=3). The offset is address bits [21:0] and the slot is bits [23:22]. This window never inverts addresses or swaps bytes, whatever the flags hold.
- R5: A byte access (`acc_size`=0) to a big-endian window has address bit 0 inverted before decoding. The register window uses flag 0 and the 16-bit memory window uses flag 1.
- R6: A halfword access (`acc_size`=1) to a big-endian window swaps the bytes of the data. On a write, `mod_wdata` is {wdata[7:0],wdata[15:8]}. On a read, `rd_data` is the swapped `mod_rdata`.
- R7: Configuration space (`acc_win`=0) holds flags 0, 1 and 2 in bit 0 of bytes 0x2B, 0x2F and 0x33. A write stores `acc_wdata[0]`, and a read returns the flag in bit 0 with all other bits zero. Other addresses read zero and ignore writes. Configuration accesses never raise `mod_req`.
- R8: An access to a slot whose `slot_present` bit is 0 raises no `mod_req`, and a read from it returns 0.
- R9: An access is accepted when `acc_valid` and `acc_ready` are both high. `mod_req` is high only in the next cycle, and `done` is high in the cycle after that, carrying `rd_data`. `acc_ready` is low from the cycle after acceptance until the cycle after `done`. A write completes with `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Decoder idle, access can be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_win | input | 2 | 0 config, 1 register window, 2 16-bit memory, 3 8-bit memory |
| acc_addr | input | 25 | Byte address within the window |
| acc_size | input | 1 | 0 = byte, 1 = halfword |
| acc_wdata | input | 16 | Host write data |
| slot_present | input | 4 | One bit per installed module |
| mod_req | output | 1 | Module request strobe |
| mod_write | output | 1 | Module request is a write |
| mod_slot | output | 2 | Target slot |
| mod_space | output | 2 | Sub-space code |
| mod_offset | output | 23 | Offset within the sub-space |
| mod_size | output | 1 | Access size to module |
| mod_wdata | output | 16 | Lane-adapted write data |
| mod_rdata | input | 16 | Module read data, valid while `mod_req` is high |
| done | output | 1 | Access complete |
| rd_data | output | 16 | Lane-adapted read result, valid with `done` |

## Verification
Two functions act in the same completion cycle: the empty-slot zeroing and the big-endian halfword byte swap. A wrong order of the two would leak swapped module data for an empty slot. The bench provokes this with a directed case and with random traffic. That traffic mixes random present masks, random flag writes and halfword reads to both endian-capable windows, while the bench drives a nonzero `mod_rdata`. Each completion is judged against a bench model. The model yields zero for an empty slot before any swap is considered, and otherwise the swapped or plain module data.

// File: rtl/laed_pkg.sv
package laed_pkg;
    localparam int OFS_W  = 23;
    localparam int DATA_W = 16;
    localparam int NFLAG  = 3;
    localparam int FLAG_BASE = 'h2B;
    localparam int FLAG_STEP = 4;

    typedef enum logic [1:0] {WIN_CFG = 2'd0, WIN_REG = 2'd1, WIN_M16 = 2'd2, WIN_M8 = 2'd3} win_e;
    typedef enum logic [1:0] {SP_IO = 2'd0, SP_ID = 2'd1, SP_INT = 2'd2, SP_MEM = 2'd3} space_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_DONE = 2'd2} state_e;

    function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] d, input logic en);
        return en ? {d[7:0], d[15:8]} : d;
    endfunction
endpackage

// File: rtl/laed_cfg_flags.sv
module laed_cfg_flags
    import laed_pkg::*;
#(
    parameter int ADDR_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              wr_en,
    input  logic              wr_bit,
    output logic [1:0]        win_be,
    output logic [7:0]        rd_byte
);
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] hit;

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(FLAG_BASE + FLAG_STEP * k);
        assign hit[k] = (cfg_addr == HIT_ADDR);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[k] <= 1'b0;
            else if (wr_en && hit[k])
                flags[k] <= wr_bit;
        end
    end

    assign win_be  = flags[1:0];
    assign rd_byte = {7'd0, |(hit & flags)};

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags)); // R7
endmodule

// File: rtl/laed_addr_split.sv
module laed_addr_split
    import laed_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int ADDR_W = 25
) (
    input  win_e              win,
    input  logic [ADDR_W-1:0] addr,
    input  logic              size_hw,
    input  logic [1:0]        win_be,
    output logic [SLOT_W-1:0] slot,
    output space_e            space,
    output logic [OFS_W-1:0]  offset,
    output logic              swap_hw
);
    logic              be;
    logic [ADDR_W-1:0] a;

    always_comb begin
        unique case (win)
            WIN_REG: be = win_be[0];
            WIN_M16: be = win_be[1];
            default: be = 1'b0;
        endcase
        a = addr;
        if (be && !size_hw)
            a[0] = ~addr[0];
        swap_hw = be && size_hw;

        slot   = '0;
        space  = SP_IO;
        offset = '0;
        unique case (win)
            WIN_REG: begin
                slot = a[8 +: SLOT_W];
                unique case (a[7:6])
                    2'd3: begin
                        space  = SP_INT;
                        offset = {{(OFS_W-6){1'b0}}, a[5:0]};
                    end
                    2'd2: begin
                        space  = SP_ID;
                        offset = {{(OFS_W-6){1'b0}}, a[5:0]};
                    end
                    default: begin
                        space  = SP_IO;
                        offset = {{(OFS_W-7){1'b0}}, a[6:0]};
                    end
                endcase
            end
            WIN_M16: begin
                slot   = a[OFS_W +: SLOT_W];
                space  = SP_MEM;
                offset = a[OFS_W-1:0];
            end
            WIN_M8: begin
                slot   = a[OFS_W-1 +: SLOT_W];
                space  = SP_MEM;
                offset = {1'b0, a[OFS_W-2:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/laddr_endian_decoder.sv
module laddr_endian_decoder
    import laed_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int SLOT_W = $clog2(NSLOT),
    parameter int ADDR_W = OFS_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic              acc_write,
    input  logic [1:0]        acc_win,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [NSLOT-1:0]  slot_present,
    output logic              mod_req,
    output logic              mod_write,
    output logic [SLOT_W-1:0] mod_slot,
    output logic [1:0]        mod_space,
    output logic [OFS_W-1:0]  mod_offset,
    output logic              mod_size,
    output logic [DATA_W-1:0] mod_wdata,
    input  logic [DATA_W-1:0] mod_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    state_e state, nxt;

    win_e              q_win;
    logic              q_write, q_size, q_swap;
    logic [SLOT_W-1:0] q_slot;
    space_e            q_space;
    logic [OFS_W-1:0]  q_ofs;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata, q_rdata;

    logic [1:0]        win_be;
    logic [7:0]        cfg_rd;
    logic [SLOT_W-1:0] d_slot;
    space_e            d_space;
    logic [OFS_W-1:0]  d_ofs;
    logic              d_swap;
    logic              accept, cfg_wr, hit_present;

    assign accept = acc_valid && (state == ST_IDLE);

    laed_addr_split #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_split (
        .win(win_e'(acc_win)), .addr(acc_addr), .size_hw(acc_size), .win_be(win_be),
        .slot(d_slot), .space(d_space), .offset(d_ofs), .swap_hw(d_swap)
    );

    assign cfg_wr = (state == ST_ISSUE) && (q_win == WIN_CFG) && q_write;

    laed_cfg_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .cfg_addr(q_addr), .wr_en(cfg_wr),
        .wr_bit(q_wdata[0]), .win_be(win_be), .rd_byte(cfg_rd)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (acc_valid) nxt = ST_ISSUE;
            ST_ISSUE: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // captured access and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_win   <= WIN_CFG;
            q_write <= 1'b0;
            q_size  <= 1'b0;
            q_swap  <= 1'b0;
            q_slot  <= '0;
            q_space <= SP_IO;
            q_ofs   <= '0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_rdata <= '0;
        end else begin
            if (accept) begin
                q_win   <= win_e'(acc_win);
                q_write <= acc_write;
                q_size  <= acc_size;
                q_swap  <= d_swap;
                q_slot  <= d_slot;
                q_space <= d_space;
                q_ofs   <= d_ofs;
                q_addr  <= acc_addr;
                q_wdata <= acc_wdata;
            end
            if (state == ST_ISSUE) begin
                if (q_write)               q_rdata <= '0;
                else if (q_win == WIN_CFG) q_rdata <= {8'd0, cfg_rd};
                else if (!hit_present)     q_rdata <= '0;
                else                       q_rdata <= lane_swap(mod_rdata, q_swap);
            end
        end
    end

    assign hit_present = slot_present[q_slot];

    // outputs
    always_comb begin
        acc_ready  = (state == ST_IDLE);
        done       = (state == ST_DONE);
        mod_req    = (state == ST_ISSUE) && (q_win != WIN_CFG) && hit_present;
        mod_write  = q_write;
        mod_slot   = q_slot;
        mod_space  = q_space;
        mod_offset = q_ofs;
        mod_size   = q_size;
        mod_wdata  = lane_swap(q_wdata, q_swap);
        rd_data    = q_rdata;
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready |=> !acc_ready && !done); // R9
    AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req |-> $past(acc_valid && acc_ready)); // R9
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req |=> done && !mod_req); // R9
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> acc_ready && !done); // R9
    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(mod_req && mod_write) |-> rd_data == '0); // R9
    AST_CFG_NO_MODULE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready && (acc_win == 2'd0) |=> !mod_req); // R7
    AST_SHORT_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req && (mod_space == 2'd1 || mod_space == 2'd2) |-> mod_offset[OFS_W-1:6] == '0); // R2
endmodule

// File: tb/sim_laddr_endian_decoder.sv
module sim_laddr_endian_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        acc_valid = 0, acc_write = 0, acc_size = 0;
    logic [1:0]  acc_win = 0;
    logic [24:0] acc_addr = 0;
    logic [15:0] acc_wdata = 0, mod_rdata = 0;
    logic [3:0]  slot_present = 4'hF;
    logic        acc_ready, mod_req, mod_write, mod_size, done;
    logic [1:0]  mod_slot, mod_space;
    logic [22:0] mod_offset;
    logic [15:0] mod_wdata, rd_data;

    laddr_endian_decoder u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_write(acc_write), .acc_win(acc_win), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .slot_present(slot_present), .mod_req(mod_req),
        .mod_write(mod_write), .mod_slot(mod_slot), .mod_space(mod_space),
        .mod_offset(mod_offset), .mod_size(mod_size), .mod_wdata(mod_wdata),
        .mod_rdata(mod_rdata), .done(done), .rd_data(rd_data)
    );

    int n_run = 0, n_fail = 0;
    logic [2:0] tb_flags = 3'b000;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic access(input logic w, input logic [1:0] win, input logic [24:0] addr,
                          input logic sz, input logic [15:0] wd, input logic [15:0] mrd);
        logic be, sw, exp_req;
        logic [24:0] a;
        logic [1:0] slot, sp;
        logic [22:0] ofs;
        logic [15:0] exp_rd;
        string tg;
        be = (win == 2'd1) ? tb_flags[0] : (win == 2'd2) ? tb_flags[1] : 1'b0;
        a = addr;
        if (be && !sz) a = a ^ 25'd1;
        sw = be && sz;
        tg = (be && !sz) ? "R5" : "R2";
        case (win)
            2'd1: begin
                slot = 2'((a >> 8) & 3);
                case ((a >> 6) & 3)
                    3: sp = 2'd2;
                    2: sp = 2'd1;
                    default: sp = 2'd0;
                endcase
                ofs = (sp != 0) ? 23'(a & 25'h3F) : 23'(a & 25'h7F);
            end
            2'd2: begin
                slot = 2'((a >> 23) & 3); sp = 2'd3; ofs = 23'(a & 25'h7FFFFF);
                if (!(be && !sz)) tg = "R3";
            end
            2'd3: begin
                slot = 2'((a >> 22) & 3); sp = 2'd3; ofs = 23'(a & 25'h3FFFFF); tg = "R4";
            end
            default: begin slot = 0; sp = 0; ofs = 0; tg = "R7"; end
        endcase
        exp_req = (win != 2'd0) && slot_present[slot];
        if (w) exp_rd = 16'h0;
        else if (win == 2'd0)
            exp_rd = (addr == 25'h2B) ? {15'd0, tb_flags[0]} :
                     (addr == 25'h2F) ? {15'd0, tb_flags[1]} :
                     (addr == 25'h33) ? {15'd0, tb_flags[2]} : 16'h0;
        else if (!exp_req) exp_rd = 16'h0;
        else exp_rd = sw ? {mrd[7:0], mrd[15:8]} : mrd;

        @(negedge clk);
        chk("R9", "acc_ready idle", acc_ready, 1);
        acc_valid = 1; acc_write = w; acc_win = win; acc_addr = addr; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 0; mod_rdata = mrd;
        chk("R9", "acc_ready busy", acc_ready, 0);
        chk((win == 2'd0) ? "R7" : "R8", "mod_req", mod_req, exp_req);
        if (exp_req) begin
            chk(tg, "slot", mod_slot, slot);
            chk(tg, "space", mod_space, sp);
            chk(tg, "offset", mod_offset, ofs);
            chk("R9", "mod_write", mod_write, w);
            if (w) chk(sw ? "R6" : "R4", "mod_wdata", mod_wdata, sw ? {wd[7:0], wd[15:8]} : wd);
        end
        @(negedge clk);
        chk("R9", "done", done, 1);
        chk(!exp_req && win != 2'd0 ? "R8" : (sw ? "R6" : (win == 2'd0 ? "R7" : "R9")),
            "rd_data", rd_data, exp_rd);
        if (w && win == 2'd0) begin
            if (addr == 25'h2B) tb_flags[0] = wd[0];
            if (addr == 25'h2F) tb_flags[1] = wd[0];
            if (addr == 25'h33) tb_flags[2] = wd[0];
        end
        @(negedge clk);
        chk("R9", "done released", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R1", "acc_ready in reset", acc_ready, 1);
        chk("R1", "done in reset", done, 0);
        chk("R1", "mod_req in reset", mod_req, 0);
        rst_n = 1;
        // R1: flags read back zero
        access(0, 2'd0, 25'h2B, 0, 0, 0);
        access(0, 2'd0, 25'h2F, 0, 0, 0);
        access(0, 2'd0, 25'h33, 0, 0, 0);
        // R7: set flag 0, read it back
        access(1, 2'd0, 25'h2B, 0, 16'h0001, 0);
        access(0, 2'd0, 25'h2B, 0, 0, 0);
        // R5: byte read in big-endian register window
        access(0, 2'd1, 25'h1C1, 0, 0, 16'h00A5);
        // R6: halfword write and read swap
        access(1, 2'd1, 25'h2A4, 1, 16'h1234, 0);
        access(0, 2'd1, 25'h084, 1, 0, 16'hABCD);
        // R4: flag 2 set and 8-bit window unaffected
        access(1, 2'd0, 25'h33, 0, 16'h0001, 0);
        access(0, 2'd3, 25'h0400001, 0, 0, 16'h005A);
        access(0, 2'd3, 25'h0C00002, 1, 0, 16'h1357);
        // R7: non-flag address ignores write, reads zero
        access(1, 2'd0, 25'h30, 0, 16'hFFFF, 0);
        access(0, 2'd0, 25'h30, 0, 0, 0);
        access(0, 2'd0, 25'h2F, 0, 0, 0);
        // R5 on 16-bit window
        access(1, 2'd0, 25'h2F, 0, 16'h0001, 0);
        access(0, 2'd2, 25'h0800003, 0, 0, 16'h00C3);
        // R8 with R6: absent slot, big-endian halfword read
        slot_present = 4'b1011;
        access(0, 2'd2, 25'h1000010, 1, 0, 16'hBEEF);
        access(1, 2'd1, 25'h240, 1, 16'h4321, 0);
        for (int i = 0; i < 400; i++) begin
            logic [1:0] win;
            logic [24:0] ad;
            win = 2'($urandom);
            ad = 25'($urandom);
            if (win == 2'd0) begin
                case ($urandom % 4)
                    0: ad = 25'h2B;
                    1: ad = 25'h2F;
                    2: ad = 25'h33;
                    default: ad = 25'($urandom % 64);
                endcase
            end
            if (($urandom % 8) == 0) slot_present = 4'($urandom);
            access(1'($urandom), win, ad, 1'($urandom), 16'($urandom), 16'($urandom | 1));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule